// File: doc/BRIEF.md
# Prioritised Eight-Line Interrupt Controller

The block gathers eight interrupt request lines, picks the most urgent one under a fixed ranking and raises a single interrupt output towards a processor. When the processor answers with an acknowledge pulse, the block returns an 8-bit vector number. The upper bits of that number come from a programmed base and the lower three bits give the winning line. A host port lets software program the block and read it back. That port has one address bit, a write strobe and a read strobe. Through it software sets up the trigger style, the end-of-service behaviour and the vector base, masks single lines, and reads the pending, in-service or mask state.

Service ends in one of two ways. Software can send a non-specific end command, which retires the most urgent line still in service. In the automatic mode, the acknowledge itself retires the line. For systems with more than eight sources, several blocks can be chained. One block acts as the master and takes the interrupt outputs of up to eight slave blocks on its own request lines, for up to 64 sources in total. On such a line the master names the slave through a select bus, and only the addressed slave supplies the vector.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, int_o is low, all mask bits read back as 1 and the pending and in-service registers read 0. Request lines are ignored until the programming sequence has ended.
- R2: Line 0 has the highest rank and line 7 the lowest. int_o is high exactly when an unmasked pending line outranks every line in service.
- R3: An acknowledge pulse produces vec_en_o high in the following cycle. vec_o then holds the base value in bits 7:3 and the winning line number in bits 2:0, and the winner's pending bit is cleared.
- R4: In edge mode a line becomes pending on a rising edge and stays pending while it is held high, until it is acknowledged. A line held high after service does not request again.
- R5: In level mode the pending bit follows the line, so a line still high after its end command requests again.
- R6: A set mask bit keeps its line out of the interrupt decision. The line still shows in the pending register.
- R7: A write with address 0, bit 4 = 0 and bit 5 = 1 is a non-specific end command. It clears the lowest-numbered set bit of the in-service register. If an acknowledge falls in the same cycle, the bit set by that acknowledge survives.
- R8: In automatic end mode, an acknowledge sets no in-service bit.
- R9: If no request qualifies when the acknowledge arrives, vec_o carries the base with line number 7 and no in-service bit is set.
- R10: Host encoding. A write with address 0 and bit 4 = 1 starts programming: bit 0 selects level mode, bit 1 automatic end, bit 2 cascade and bit 3 master, and the pending and in-service registers are cleared. The following writes with address 1 load, in order, the base (bits 7:3), then the cascade word if cascade is on, then the mask. A write with address 0, bit 4 = 0 and bit 3 = 1 selects the register read at address 0: bit 0 = 1 for in-service, 0 for pending. A read strobe returns data on host_rdata_o one cycle later, and address 1 reads the mask.
- R11: For a cascade master, the cascade word is a map of the lines that carry slaves. When such a line wins, casc_act_o is high and casc_sel_o gives the line number. The acknowledge then sets the in-service bit, but vec_en_o stays low.
- R12: For a cascade slave, the cascade word holds its identity in bits 2:0. An acknowledge is acted on only if casc_sel_i equals that identity, and otherwise it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_i | input | 8 | Interrupt request lines |
| int_o | output | 1 | Interrupt request to the processor |
| ack_i | input | 1 | Acknowledge pulse, one cycle |
| vec_o | output | 8 | Returned vector number |
| vec_en_o | output | 1 | This block supplies vec_o in this cycle |
| host_addr_i | input | 1 | Register select bit |
| host_wr_i | input | 1 | Write strobe |
| host_rd_i | input | 1 | Read strobe |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data |
| casc_sel_i | input | 3 | Slave select seen by a slave block |
| casc_sel_o | output | 3 | Slave select driven by a master block |
| casc_act_o | output | 1 | Master names a slave on casc_sel_o |

## Verification
An acknowledge and a non-specific end command can both land on the in-service register in the same clock. The acknowledge sets the winner's bit while the end command clears the lowest-numbered bit already set. The bench provokes this by putting line 3 in service and raising line 1. It then drives the acknowledge pulse and the end-command write in the same cycle. It expects vector base+1 and an in-service readback of only bit 1. This shows that line 3 was retired and the new bit was not lost.

// File: rtl/pic_pkg.sv
package pic_pkg;

   typedef enum logic [1:0] {
      CFG_NONE,
      CFG_BASE,
      CFG_CASC,
      CFG_DONE
   } cfg_st_e;

   typedef struct packed {
      logic level;
      logic auto_eoi;
      logic casc;
      logic master;
   } pic_mode_t;

   // address-0 command bit positions
   localparam int CMD_INIT_BIT  = 4;
   localparam int INIT_LVL_BIT  = 0;
   localparam int INIT_AEOI_BIT = 1;
   localparam int INIT_CASC_BIT = 2;
   localparam int INIT_MSTR_BIT = 3;
   localparam int OP_EOI_BIT    = 5;
   localparam int OP_RSEL_BIT   = 3;
   localparam int OP_RISR_BIT   = 0;

endpackage

// File: rtl/pic_first_set.sv
module pic_first_set #(
   parameter int W  = 8,
   parameter int IW = 3
) (
   input  logic [W-1:0]  vec,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/pic_req_bank.sv
module pic_req_bank #(
   parameter int N_REQ = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             level,
   input  logic             clear_all,
   input  logic [N_REQ-1:0] ir,
   input  logic [N_REQ-1:0] ack_clr,
   output logic [N_REQ-1:0] irr
);
   for (genvar g = 0; g < N_REQ; g++) begin : g_line
      logic prev_q;
      logic req_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            req_q  <= 1'b0;
         end else begin
            prev_q <= ir[g];
            if (clear_all || !enable)
               req_q <= 1'b0;
            else if (level)
               req_q <= ir[g] & ~ack_clr[g];
            else
               req_q <= (req_q | (ir[g] & ~prev_q)) & ir[g] & ~ack_clr[g];
         end
      end

      assign irr[g] = req_q;
   end
endmodule

// File: rtl/pic_host_regs.sv
module pic_host_regs
   import pic_pkg::*;
#(
   parameter int N_REQ      = 8,
   parameter int DATA_W     = 8,
   parameter int IDX_W      = 3,
   parameter bit CASCADE_EN = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    addr,
   input  logic                    wr,
   input  logic                    rd,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [N_REQ-1:0]        irr,
   input  logic [N_REQ-1:0]        isr,
   output pic_mode_t               mode,
   output logic [DATA_W-IDX_W-1:0] base_hi,
   output logic [N_REQ-1:0]        slave_map,
   output logic [IDX_W-1:0]        slave_id,
   output logic [N_REQ-1:0]        mask,
   output logic                    cfg_done,
   output logic                    init_pulse,
   output logic                    eoi_pulse,
   output logic [DATA_W-1:0]       rdata
);
   cfg_st_e st_q;
   logic    rsel_isr_q;

   assign cfg_done   = (st_q == CFG_DONE);
   assign init_pulse = wr & ~addr & wdata[CMD_INIT_BIT];
   assign eoi_pulse  = wr & ~addr & ~wdata[CMD_INIT_BIT] & wdata[OP_EOI_BIT] & cfg_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= CFG_NONE;
         mode       <= '0;
         base_hi    <= '0;
         slave_map  <= '0;
         slave_id   <= '0;
         mask       <= '1;
         rsel_isr_q <= 1'b0;
         rdata      <= '0;
      end else begin
         if (rd)
            rdata <= addr ? DATA_W'(mask) : (rsel_isr_q ? DATA_W'(isr) : DATA_W'(irr));
         if (wr) begin
            if (!addr && wdata[CMD_INIT_BIT]) begin
               mode.level    <= wdata[INIT_LVL_BIT];
               mode.auto_eoi <= wdata[INIT_AEOI_BIT];
               mode.casc     <= wdata[INIT_CASC_BIT] & CASCADE_EN;
               mode.master   <= wdata[INIT_MSTR_BIT];
               rsel_isr_q    <= 1'b0;
               st_q          <= CFG_BASE;
            end else if (!addr) begin
               if (wdata[OP_RSEL_BIT])
                  rsel_isr_q <= wdata[OP_RISR_BIT];
            end else begin
               case (st_q)
                  CFG_BASE: begin
                     base_hi <= wdata[DATA_W-1:IDX_W];
                     st_q    <= mode.casc ? CFG_CASC : CFG_DONE;
                  end
                  CFG_CASC: begin
                     slave_map <= wdata[N_REQ-1:0];
                     slave_id  <= wdata[IDX_W-1:0];
                     st_q      <= CFG_DONE;
                  end
                  CFG_DONE: mask <= wdata[N_REQ-1:0];
                  default:  ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/pic_service.sv
module pic_service #(
   parameter int N_REQ  = 8,
   parameter int DATA_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_REQ-1:0]        irr,
   input  logic [N_REQ-1:0]        mask,
   input  logic                    cfg_done,
   input  logic                    init_pulse,
   input  logic                    eoi_pulse,
   input  logic                    auto_eoi,
   input  logic                    casc_master,
   input  logic                    casc_slave,
   input  logic [N_REQ-1:0]        slave_map,
   input  logic [IDX_W-1:0]        slave_id,
   input  logic [DATA_W-IDX_W-1:0] base_hi,
   input  logic                    ack,
   input  logic [IDX_W-1:0]        casc_sel_in,
   output logic [N_REQ-1:0]        isr,
   output logic                    int_req,
   output logic [N_REQ-1:0]        ack_clr,
   output logic [DATA_W-1:0]       vec,
   output logic                    vec_en,
   output logic [IDX_W-1:0]        casc_sel_out,
   output logic                    casc_act
);
   localparam logic [N_REQ-1:0] ONE = N_REQ'(1);

   logic [N_REQ-1:0] pend;
   logic             p_found, s_found;
   logic [IDX_W-1:0] p_idx, s_idx;
   logic             win, ack_take, slave_line;
   logic [N_REQ-1:0] eoi_clr, ack_set;

   assign pend = irr & ~mask;

   pic_first_set #(.W(N_REQ), .IW(IDX_W)) u_pend_pick (
      .vec(pend), .found(p_found), .idx(p_idx));

   pic_first_set #(.W(N_REQ), .IW(IDX_W)) u_isr_pick (
      .vec(isr), .found(s_found), .idx(s_idx));

   assign win        = cfg_done & p_found & (~s_found | (p_idx < s_idx));
   assign ack_take   = ack & cfg_done & (~casc_slave | (casc_sel_in == slave_id));
   assign slave_line = casc_master & slave_map[p_idx];
   assign eoi_clr    = (eoi_pulse & s_found) ? (ONE << s_idx) : '0;
   assign ack_set    = (ack_take & win & ~auto_eoi) ? (ONE << p_idx) : '0;
   assign ack_clr    = (ack_take & win) ? (ONE << p_idx) : '0;

   assign int_req      = win;
   assign casc_act     = win & slave_line;
   assign casc_sel_out = win ? p_idx : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr    <= '0;
         vec    <= '0;
         vec_en <= 1'b0;
      end else begin
         isr    <= init_pulse ? '0 : ((isr & ~eoi_clr) | ack_set);
         vec_en <= ack_take & ~(win & slave_line);
         if (ack_take)
            vec <= {base_hi, (win ? p_idx : {IDX_W{1'b1}})};
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import pic_pkg::*;
#(
   parameter int N_REQ      = 8,
   parameter int DATA_W     = 8,
   parameter bit CASCADE_EN = 1'b1,
   localparam int IDX_W     = $clog2(N_REQ)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_REQ-1:0]  ir_i,
   output logic              int_o,
   input  logic              ack_i,
   output logic [DATA_W-1:0] vec_o,
   output logic              vec_en_o,
   input  logic              host_addr_i,
   input  logic              host_wr_i,
   input  logic              host_rd_i,
   input  logic [DATA_W-1:0] host_wdata_i,
   output logic [DATA_W-1:0] host_rdata_o,
   input  logic [IDX_W-1:0]  casc_sel_i,
   output logic [IDX_W-1:0]  casc_sel_o,
   output logic              casc_act_o
);
   if (N_REQ != (1 << IDX_W)) begin : g_bad_count
      $error("N_REQ must be a power of two");
   end
   if (N_REQ > DATA_W || DATA_W <= IDX_W) begin : g_bad_width
      $error("DATA_W must hold N_REQ bits and exceed the index width");
   end

   pic_mode_t               mode_q;
   logic [DATA_W-IDX_W-1:0] base_w;
   logic [N_REQ-1:0]        smap_w, mask_q, irr_q, isr_q, ackclr_w;
   logic [IDX_W-1:0]        sid_w, sel_w;
   logic                    cfg_done_w, init_w, eoi_w, act_w, auto_eoi_w;

   assign auto_eoi_w = mode_q.auto_eoi;

   pic_host_regs #(.N_REQ(N_REQ), .DATA_W(DATA_W), .IDX_W(IDX_W),
                   .CASCADE_EN(CASCADE_EN)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(host_addr_i), .wr(host_wr_i),
      .rd(host_rd_i), .wdata(host_wdata_i), .irr(irr_q), .isr(isr_q),
      .mode(mode_q), .base_hi(base_w), .slave_map(smap_w), .slave_id(sid_w),
      .mask(mask_q), .cfg_done(cfg_done_w), .init_pulse(init_w),
      .eoi_pulse(eoi_w), .rdata(host_rdata_o));

   pic_req_bank #(.N_REQ(N_REQ)) u_req (
      .clk(clk), .rst_n(rst_n), .enable(cfg_done_w), .level(mode_q.level),
      .clear_all(init_w), .ir(ir_i), .ack_clr(ackclr_w), .irr(irr_q));

   pic_service #(.N_REQ(N_REQ), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_svc (
      .clk(clk), .rst_n(rst_n), .irr(irr_q), .mask(mask_q),
      .cfg_done(cfg_done_w), .init_pulse(init_w), .eoi_pulse(eoi_w),
      .auto_eoi(auto_eoi_w), .casc_master(mode_q.casc & mode_q.master),
      .casc_slave(mode_q.casc & ~mode_q.master), .slave_map(smap_w),
      .slave_id(sid_w), .base_hi(base_w), .ack(ack_i),
      .casc_sel_in(casc_sel_i), .isr(isr_q), .int_req(int_o),
      .ack_clr(ackclr_w), .vec(vec_o), .vec_en(vec_en_o),
      .casc_sel_out(sel_w), .casc_act(act_w));

   if (CASCADE_EN) begin : g_casc
      assign casc_sel_o = sel_w;
      assign casc_act_o = act_w;
   end else begin : g_nocasc
      assign casc_sel_o = '0;
      assign casc_act_o = 1'b0;
   end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
   parameter int N_REQ  = 8,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              int_o,
   input logic              ack_i,
   input logic              vec_en_o,
   input logic              casc_act_o,
   input logic              host_wr_i,
   input logic              host_addr_i,
   input logic [DATA_W-1:0] host_wdata_i,
   input logic [N_REQ-1:0]  irr,
   input logic [N_REQ-1:0]  isr,
   input logic [N_REQ-1:0]  mask,
   input logic              cfg_done,
   input logic              auto_eoi
);
   // R1
   unconfigured_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_done |-> !int_o);

   // R2
   int_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> ((irr & ~mask) != '0));

   // R3
   vector_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_en_o |-> $past(ack_i));

   // R7
   eoi_clears_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_i && !host_addr_i && !host_wdata_i[4] && host_wdata_i[5] && !ack_i)
      |=> (($countones(isr) + 1 >= $countones($past(isr))) && ((isr & ~$past(isr)) == '0)));

   // R8
   auto_end_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_eoi && cfg_done) |-> (isr == '0));

   // R9
   spurious_no_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !int_o && !host_wr_i) |=> $stable(isr));

   // R11
   cascade_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      casc_act_o |-> int_o);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_REQ(N_REQ), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .int_o(int_o), .ack_i(ack_i), .vec_en_o(vec_en_o),
   .casc_act_o(casc_act_o), .host_wr_i(host_wr_i), .host_addr_i(host_addr_i),
   .host_wdata_i(host_wdata_i), .irr(irr_q), .isr(isr_q), .mask(mask_q),
   .cfg_done(cfg_done_w), .auto_eoi(auto_eoi_w));

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ir = '0;
   logic       ack = 1'b0;
   logic       haddr = 1'b0, hwr = 1'b0, hrd = 1'b0;
   logic [7:0] hwdata = '0;
   logic [2:0] csel_in = '0;
   logic       int_w, ven_w, cact_w;
   logic [7:0] vec_w, rdata_w;
   logic [2:0] csel_out;
   int         n_chk = 0, n_fail = 0;
   logic [7:0] rd;

   always #4 clk = ~clk;

   prio_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ir_i(ir), .int_o(int_w), .ack_i(ack),
      .vec_o(vec_w), .vec_en_o(ven_w), .host_addr_i(haddr), .host_wr_i(hwr),
      .host_rd_i(hrd), .host_wdata_i(hwdata), .host_rdata_o(rdata_w),
      .casc_sel_i(csel_in), .casc_sel_o(csel_out), .casc_act_o(cact_w));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hw(input logic a, input logic [7:0] d);
      @(negedge clk); haddr = a; hwdata = d; hwr = 1'b1;
      @(negedge clk); hwr = 1'b0;
   endtask

   task automatic hr(input logic a, output logic [7:0] d);
      @(negedge clk); haddr = a; hrd = 1'b1;
      @(negedge clk); hrd = 1'b0; d = rdata_w;
   endtask

   task automatic read_isr(output logic [7:0] d);
      hw(1'b0, 8'h09);
      hr(1'b0, d);
   endtask

   task automatic do_ack();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   task automatic cfg(input bit lvl, input bit aeoi, input bit cs, input bit ms,
                      input logic [7:0] base, input logic [7:0] cw);
      hw(1'b0, {4'b0001, ms, cs, aeoi, lvl});
      hw(1'b1, base);
      if (cs) hw(1'b1, cw);
      hw(1'b1, 8'h00);
   endtask

   task automatic set_ir(input logic [7:0] v);
      @(negedge clk); ir = v;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state and unconfigured block
      chk(!int_w && !ven_w, "R1 reset outputs", {int_w, ven_w}, 0);
      hr(1'b1, rd); chk(rd == 8'hFF, "R1 reset mask", rd, 8'hFF);
      set_ir(8'hFF);
      chk(!int_w, "R1 request before config", int_w, 0);
      hr(1'b0, rd); chk(rd == 8'h00, "R1 pending before config", rd, 0);
      set_ir(8'h00);

      // R10 edge mode, base 0x40
      cfg(1'b0, 1'b0, 1'b0, 1'b0, 8'h40, 8'h00);
      hr(1'b1, rd); chk(rd == 8'h00, "R10 mask write readback", rd, 0);

      // R3 R4 sweep of every line
      for (int i = 0; i < 8; i++) begin
         set_ir(8'(1 << i));
         chk(int_w, "R2 single line raises int", int_w, 1);
         do_ack();
         chk(ven_w && vec_w == 8'(8'h40 + i), "R3 vector per line", vec_w, 8'h40 + i);
         chk(!int_w, "R2 line in service blocks itself", int_w, 0);
         read_isr(rd); chk(rd == 8'(1 << i), "R10 isr readback", rd, 1 << i);
         hw(1'b0, 8'h20);
         read_isr(rd); chk(rd == 8'h00, "R7 end command clears", rd, 0);
         chk(!int_w, "R4 held line no re-request", int_w, 0);
         set_ir(8'h00);
      end

      // R2 all lines at once, ranked order
      set_ir(8'hFF);
      for (int k = 0; k < 8; k++) begin
         chk(int_w, "R2 pending raises int", int_w, 1);
         do_ack();
         chk(vec_w == 8'(8'h40 + k), "R2 rank order", vec_w, 8'h40 + k);
         hw(1'b0, 8'h20);
      end
      chk(!int_w, "R4 all served", int_w, 0);
      set_ir(8'h00);

      // R6 masking
      hw(1'b1, 8'h04);
      set_ir(8'h04);
      chk(!int_w, "R6 masked line silent", int_w, 0);
      hw(1'b0, 8'h08); hr(1'b0, rd); chk(rd == 8'h04, "R6 masked still pending", rd, 8'h04);
      hr(1'b1, rd); chk(rd == 8'h04, "R10 mask readback", rd, 8'h04);
      hw(1'b1, 8'h00);
      chk(int_w, "R6 unmask raises int", int_w, 1);
      do_ack(); hw(1'b0, 8'h20); set_ir(8'h00);

      // R2 nesting and R7 end order
      set_ir(8'h20); do_ack();
      set_ir(8'h60);
      chk(!int_w, "R2 lower rank blocked", int_w, 0);
      set_ir(8'h64);
      chk(int_w, "R2 higher rank nests", int_w, 1);
      do_ack(); chk(vec_w == 8'h42, "R3 nested vector", vec_w, 8'h42);
      read_isr(rd); chk(rd == 8'h24, "R2 nested isr", rd, 8'h24);
      hw(1'b0, 8'h20);
      read_isr(rd); chk(rd == 8'h20, "R7 clears highest rank", rd, 8'h20);
      hw(1'b0, 8'h20);
      chk(int_w, "R2 line 6 now allowed", int_w, 1);
      set_ir(8'h00);
      chk(!int_w, "R4 dropped line withdraws", int_w, 0);

      // R7 acknowledge and end command in the same cycle
      set_ir(8'h08); do_ack();
      set_ir(8'h0A);
      @(negedge clk); ack = 1'b1; haddr = 1'b0; hwdata = 8'h20; hwr = 1'b1;
      @(negedge clk); ack = 1'b0; hwr = 1'b0;
      chk(ven_w && vec_w == 8'h41, "R7 same-cycle vector", vec_w, 8'h41);
      read_isr(rd); chk(rd == 8'h02, "R7 same-cycle isr", rd, 8'h02);
      hw(1'b0, 8'h20); set_ir(8'h00);

      // R9 spurious
      set_ir(8'h10);
      set_ir(8'h00);
      do_ack();
      chk(ven_w && vec_w == 8'h47, "R9 spurious vector", vec_w, 8'h47);
      read_isr(rd); chk(rd == 8'h00, "R9 no isr", rd, 0);

      // R5 level mode, base 0x80
      cfg(1'b1, 1'b0, 1'b0, 1'b0, 8'h80, 8'h00);
      set_ir(8'h40);
      do_ack(); chk(vec_w == 8'h86, "R5 level vector", vec_w, 8'h86);
      hw(1'b0, 8'h20);
      chk(int_w, "R5 held level re-requests", int_w, 1);
      do_ack(); hw(1'b0, 8'h20);
      set_ir(8'h00);
      chk(!int_w, "R5 low level no request", int_w, 0);

      // R8 automatic end, base 0x20
      cfg(1'b0, 1'b1, 1'b0, 1'b0, 8'h20, 8'h00);
      set_ir(8'h04); do_ack();
      chk(vec_w == 8'h22, "R8 auto vector", vec_w, 8'h22);
      read_isr(rd); chk(rd == 8'h00, "R8 isr stays empty", rd, 0);
      set_ir(8'h24);
      chk(int_w, "R8 lower line free to request", int_w, 1);
      do_ack(); chk(vec_w == 8'h25, "R8 second vector", vec_w, 8'h25);
      set_ir(8'h00);

      // R11 cascade master, slave on line 4
      cfg(1'b0, 1'b0, 1'b1, 1'b1, 8'h08, 8'h10);
      set_ir(8'h10);
      chk(cact_w && csel_out == 3'd4, "R11 slave named", csel_out, 4);
      do_ack(); chk(!ven_w, "R11 master silent on slave line", ven_w, 0);
      read_isr(rd); chk(rd == 8'h10, "R11 master isr", rd, 8'h10);
      hw(1'b0, 8'h20); set_ir(8'h00);
      set_ir(8'h08);
      chk(!cact_w, "R11 plain line no select", cact_w, 0);
      do_ack(); chk(ven_w && vec_w == 8'h0B, "R11 plain line vector", vec_w, 8'h0B);
      hw(1'b0, 8'h20); set_ir(8'h00);

      // R12 cascade slave with identity 5
      cfg(1'b0, 1'b0, 1'b1, 1'b0, 8'hC0, 8'h05);
      set_ir(8'h02);
      csel_in = 3'd2;
      do_ack();
      chk(!ven_w, "R12 other identity ignored", ven_w, 0);
      chk(int_w, "R12 request kept", int_w, 1);
      csel_in = 3'd5;
      do_ack();
      chk(ven_w && vec_w == 8'hC1, "R12 own identity vector", vec_w, 8'hC1);
      set_ir(8'h00);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule